// File: doc/BRIEF.md
# Dual-Modulus Swallow-Counter Synthesizer Divider

This block holds the two digital division chains that sit in front of a phase-frequency detector in an integer-N frequency synthesizer. The feedback chain takes the oscillator clock, which is the block clock `clk`. It models a two-modulus prescaler of 24 or 25. A main counter of N prescaler outputs follows it, and a swallow counter A chooses how many of those N prescaler cycles use the longer modulus. The result is one output pulse every 24·N + A oscillator cycles.

The reference chain counts both rising and falling transitions of the reference level, which doubles its rate. It then divides that edge count by R, so the comparison rate is twice the reference frequency over R.

Settings arrive through a write strobe together with N, A and R. Each write is checked for legality. An illegal write is rejected and raises a flag, and the settings already in use remain in force. An accepted write is held pending. The feedback chain takes the pending values at its next terminal count, and the reference chain does the same at its own terminal count. Neither output ever has a shortened period.

Top module: `pll_swallow_div`

## Requirements
- R1: While `rstN` is low, and on the cycle it is released, `fbPulse`, `refPulse` and `cfgBad` are 0. The divider starts with N=4, A=2 and R=3.
- R2: `fbPulse` is high for exactly one cycle, once every 24·N + A clock cycles. The first pulse follows the (24·N + A)-th rising edge after reset release.
- R3: Within each feedback period, the first A prescaler cycles last 25 clocks and the remaining N−A last 24. The two limits therefore give A=0 → 24·N and A=N → 25·N clocks.
- R4: Every change of `refIn` seen at a rising clock edge counts as one doubled reference edge, whether the level rises or falls. `refPulse` is high for one cycle after every R such edges.
- R5: A write is illegal when N < 3, R < 3, or A > N. After an illegal write, `cfgBad` is 1 from the next cycle, and both output periods continue with the settings in use before that write.
- R6: A legal write sets `cfgBad` to 0 from the next cycle.
- R7: Accepted values reach the feedback chain only after its current period ends with a pulse, and they reach the reference chain only after its current period ends with a pulse. No output period is cut short.
- R8: While `refIn` holds steady, `refPulse` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; every rising edge is one feedback input cycle |
| rstN | input | 1 | Active-low synchronous reset |
| refIn | input | 1 | Reference level, sampled on `clk` |
| cfgWrite | input | 1 | One-cycle strobe that offers a new setting |
| cfgMain | input | 11 | Main counter value N |
| cfgSwallow | input | 5 | Swallow counter value A |
| cfgRef | input | 9 | Reference divider value R |
| fbPulse | output | 1 | One-cycle feedback pulse for the phase detector |
| refPulse | output | 1 | One-cycle reference pulse for the phase detector |
| cfgBad | output | 1 | Last write was rejected as illegal |

## Verification
The feedback chain is run with A strictly between 0 and N, with A=0, with A=N and with a large N. Each case changes how the 25-cycle and 24-cycle prescaler periods mix, so an error in the swallow hand-over or the reload shifts the pulse by a known number of clocks. The reference chain is driven with a level that toggles every cycle and with one that toggles every other cycle, which shows that both edge directions are counted. It is also held steady. Writes land in the middle of periods so the deferred take-over can be told apart from an immediate one. Each of the three illegal conditions is offered on its own, which separates the individual legality tests.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  // terminal-count strobes passed from the counter chains to the control
  typedef struct packed {
    logic fbTc;
    logic refTc;
  } divTick_t;
endpackage

// File: rtl/pll_div_ctrl.sv
module pll_div_ctrl
  import pll_div_pkg::*;
#(
  parameter int MAIN_W   = 11,
  parameter int SWAL_W   = 5,
  parameter int REFD_W   = 9,
  parameter int MIN_N    = 3,
  parameter int MIN_R    = 3,
  parameter int DEF_MAIN = 4,
  parameter int DEF_SWAL = 2,
  parameter int DEF_REF  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [MAIN_W-1:0] cfgMain,
  input  logic [SWAL_W-1:0] cfgSwallow,
  input  logic [REFD_W-1:0] cfgRef,
  input  divTick_t          tick,
  output logic [MAIN_W-1:0] actN,
  output logic [REFD_W-1:0] actR,
  output logic [SWAL_W-1:0] nxtA,
  output logic              cfgBad
);
  logic [SWAL_W-1:0] actA;
  logic [MAIN_W-1:0] pendN, nxtN;
  logic [SWAL_W-1:0] pendA;
  logic [REFD_W-1:0] pendR, nxtR;
  logic              pendFb, pendRef;
  logic              writeLegal;

  assign writeLegal = (cfgMain >= MAIN_W'(MIN_N)) &&
                      (cfgRef >= REFD_W'(MIN_R)) &&
                      (MAIN_W'(cfgSwallow) <= cfgMain);

  assign nxtN = pendFb  ? pendN : actN;
  assign nxtA = pendFb  ? pendA : actA;
  assign nxtR = pendRef ? pendR : actR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actN    <= MAIN_W'(DEF_MAIN);
      actA    <= SWAL_W'(DEF_SWAL);
      actR    <= REFD_W'(DEF_REF);
      pendN   <= '0;
      pendA   <= '0;
      pendR   <= '0;
      pendFb  <= 1'b0;
      pendRef <= 1'b0;
      cfgBad  <= 1'b0;
    end else begin
      if (tick.fbTc) begin
        actN   <= nxtN;
        actA   <= nxtA;
        pendFb <= 1'b0;
      end
      if (tick.refTc) begin
        actR    <= nxtR;
        pendRef <= 1'b0;
      end
      // a write on a terminal cycle becomes pending after the old one is consumed
      if (cfgWrite) begin
        cfgBad <= !writeLegal;
        if (writeLegal) begin
          pendN   <= cfgMain;
          pendA   <= cfgSwallow;
          pendR   <= cfgRef;
          pendFb  <= 1'b1;
          pendRef <= 1'b1;
        end
      end
    end
  end

  assert_bad_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && !writeLegal) |=> cfgBad);

  assert_clear_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && writeLegal) |=> !cfgBad);

  assert_active_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    (actN >= MAIN_W'(MIN_N)) && (MAIN_W'(actA) <= actN) && (actR >= REFD_W'(MIN_R)));
endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain
  import pll_div_pkg::*;
#(
  parameter int MAIN_W   = 11,
  parameter int SWAL_W   = 5,
  parameter int REFD_W   = 9,
  parameter int PRESCALE = 24,
  parameter int DEF_SWAL = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refIn,
  input  logic [MAIN_W-1:0] actN,
  input  logic [REFD_W-1:0] actR,
  input  logic [SWAL_W-1:0] nxtA,
  output divTick_t          tick,
  output logic              fbPulse,
  output logic              refPulse
);
  localparam int PRE_W = $clog2(PRESCALE + 1);

  logic [PRE_W-1:0]  preCnt;
  logic [MAIN_W-1:0] mainCnt;
  logic [SWAL_W-1:0] swRemain, swAfter;
  logic              preTc, fbTc;
  logic [REFD_W-1:0] refCnt;
  logic              refPrev, refEdge, refTc;

  // count-down start for one prescaler cycle: 25 clocks while swallowing, else 24
  function automatic logic [PRE_W-1:0] preLoad(input logic longCycle);
    return longCycle ? PRE_W'(PRESCALE) : PRE_W'(PRESCALE - 1);
  endfunction

  assign preTc   = (preCnt == '0);
  assign fbTc    = preTc && (mainCnt == actN - MAIN_W'(1));
  assign swAfter = (swRemain != '0) ? swRemain - SWAL_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt   <= preLoad(DEF_SWAL != 0);
      mainCnt  <= '0;
      swRemain <= SWAL_W'(DEF_SWAL);
      fbPulse  <= 1'b0;
    end else begin
      fbPulse <= fbTc;
      if (fbTc) begin
        mainCnt  <= '0;
        swRemain <= nxtA;
        preCnt   <= preLoad(nxtA != '0);
      end else if (preTc) begin
        mainCnt  <= mainCnt + MAIN_W'(1);
        swRemain <= swAfter;
        preCnt   <= preLoad(swAfter != '0);
      end else begin
        preCnt <= preCnt - PRE_W'(1);
      end
    end
  end

  // doubled reference: every level change is one edge
  assign refEdge = refIn ^ refPrev;
  assign refTc   = refEdge && (refCnt == actR - REFD_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPrev  <= 1'b0;
      refCnt   <= '0;
      refPulse <= 1'b0;
    end else begin
      refPrev  <= refIn;
      refPulse <= refTc;
      if (refTc)        refCnt <= '0;
      else if (refEdge) refCnt <= refCnt + REFD_W'(1);
    end
  end

  assign tick.fbTc  = fbTc;
  assign tick.refTc = refTc;

  assert_fb_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    fbPulse |=> !fbPulse);

  assert_main_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    mainCnt < actN);

  assert_ref_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    refPulse |=> !refPulse);

  assert_ref_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    refCnt < actR);
endmodule

// File: rtl/pll_swallow_div.sv
module pll_swallow_div
  import pll_div_pkg::*;
#(
  parameter int MAIN_W   = 11,
  parameter int SWAL_W   = 5,
  parameter int REFD_W   = 9,
  parameter int PRESCALE = 24,
  parameter int MIN_N    = 3,
  parameter int MIN_R    = 3,
  parameter int DEF_MAIN = 4,
  parameter int DEF_SWAL = 2,
  parameter int DEF_REF  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refIn,
  input  logic              cfgWrite,
  input  logic [MAIN_W-1:0] cfgMain,
  input  logic [SWAL_W-1:0] cfgSwallow,
  input  logic [REFD_W-1:0] cfgRef,
  output logic              fbPulse,
  output logic              refPulse,
  output logic              cfgBad
);
  divTick_t          tick;
  logic [MAIN_W-1:0] actN;
  logic [REFD_W-1:0] actR;
  logic [SWAL_W-1:0] nxtA;

  pll_div_ctrl #(
    .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .REFD_W(REFD_W),
    .MIN_N(MIN_N), .MIN_R(MIN_R),
    .DEF_MAIN(DEF_MAIN), .DEF_SWAL(DEF_SWAL), .DEF_REF(DEF_REF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite),
    .cfgMain(cfgMain), .cfgSwallow(cfgSwallow), .cfgRef(cfgRef),
    .tick(tick), .actN(actN), .actR(actR), .nxtA(nxtA), .cfgBad(cfgBad)
  );

  pll_div_chain #(
    .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .REFD_W(REFD_W),
    .PRESCALE(PRESCALE), .DEF_SWAL(DEF_SWAL)
  ) u_chain (
    .clk(clk), .rstN(rstN), .refIn(refIn),
    .actN(actN), .actR(actR), .nxtA(nxtA),
    .tick(tick), .fbPulse(fbPulse), .refPulse(refPulse)
  );
endmodule

// File: tb/pll_swallow_div_tb.sv
module pll_swallow_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCH_CYCLES = 50000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refIn = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [10:0] cfgMain = '0;
  logic [4:0]  cfgSwallow = '0;
  logic [8:0]  cfgRef = '0;
  logic        fbPulse, refPulse, cfgBad;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit comparing = 1'b0;
  string phaseTag = "R1";
  int refHalf = 0;
  int fbSeen = 0;
  int refSeen = 0;

  // behavioural reference model state
  int  fbCnt, fbPer, pendFbPer;
  bit  havePendFb;
  int  refEdges, refPer, pendRefPer;
  bit  havePendRef;
  bit  refPrevM;
  bit  expFb, expRef, expBad;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_swallow_div u_dut (
    .clk(clk), .rstN(rstN), .refIn(refIn), .cfgWrite(cfgWrite),
    .cfgMain(cfgMain), .cfgSwallow(cfgSwallow), .cfgRef(cfgRef),
    .fbPulse(fbPulse), .refPulse(refPulse), .cfgBad(cfgBad)
  );

  // model advances on the same edge as the design, from the inputs it sees there
  always @(posedge clk) begin
    if (!rstN) begin
      fbCnt = 0; fbPer = 24*4 + 2; havePendFb = 0; pendFbPer = 0;
      refEdges = 0; refPer = 3; havePendRef = 0; pendRefPer = 0;
      refPrevM = 0; expFb = 0; expRef = 0; expBad = 0;
    end else begin
      fbCnt++;
      expFb = (fbCnt == fbPer);
      if (expFb) begin
        fbCnt = 0;
        if (havePendFb) begin fbPer = pendFbPer; havePendFb = 0; end
      end
      expRef = 0;
      if (refIn != refPrevM) begin
        refEdges++;
        if (refEdges == refPer) begin
          expRef = 1; refEdges = 0;
          if (havePendRef) begin refPer = pendRefPer; havePendRef = 0; end
        end
      end
      refPrevM = refIn;
      if (cfgWrite) begin
        bit legal;
        legal = (cfgMain >= 3) && (cfgRef >= 3) && (cfgSwallow <= cfgMain);
        expBad = !legal;
        if (legal) begin
          pendFbPer = 24*int'(cfgMain) + int'(cfgSwallow); havePendFb = 1;
          pendRefPer = int'(cfgRef); havePendRef = 1;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (comparing) begin
      check(phaseTag, fbPulse, expFb, "fbPulse");
      check(phaseTag, refPulse, expRef, "refPulse");
      check(phaseTag, cfgBad, expBad, "cfgBad");
      if (fbPulse) fbSeen++;
      if (refPulse) refSeen++;
    end
  end

  // reference level generator: toggles every refHalf cycles, holds when 0
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (refHalf > 0) begin
        cnt++;
        if (cnt >= refHalf) begin refIn = ~refIn; cnt = 0; end
      end else cnt = 0;
    end
  end

  task automatic runCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(input int n, input int a, input int r);
    @(negedge clk);
    cfgMain = 11'(n); cfgSwallow = 5'(a); cfgRef = 9'(r); cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  initial begin
    phaseTag = "R1";
    comparing = 1'b1;
    runCycles(4);
    rstN = 1'b1;
    runCycles(1);

    phaseTag = "R2 R8";                 // defaults: period 98, reference held
    fbSeen = 0; refSeen = 0;
    runCycles(400);
    check("R2", int'(fbSeen >= 4), 1, "feedback pulses seen");
    check("R8", refSeen, 0, "reference pulses with steady input");

    phaseTag = "R4";                    // toggle every cycle, R=3
    refHalf = 1; refSeen = 0;
    runCycles(120);
    check("R4", int'(refSeen >= 30), 1, "reference pulses seen");
    refHalf = 2;
    runCycles(120);

    phaseTag = "R3 R7";                 // A=0 -> 72 cycles, change mid-period
    runCycles(37);
    writeCfg(3, 0, 5);
    runCycles(400);
    writeCfg(5, 5, 3);                  // A=N -> 125 cycles
    runCycles(500);

    phaseTag = "R5";
    writeCfg(2, 0, 7);                  // N below minimum
    runCycles(300);
    writeCfg(6, 1, 2);                  // R below minimum
    runCycles(300);
    writeCfg(5, 6, 4);                  // A above N
    runCycles(300);

    phaseTag = "R6 R7";
    writeCfg(20, 17, 7);                // 497 cycles
    refHalf = 1;
    runCycles(1200);
    writeCfg(3, 3, 4);
    runCycles(400);

    comparing = 1'b0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCH_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule